// File: doc/BRIEF.md
# Synchronous FIFO Drain Monitor

This block sits on the FPGA side of an 8-bit synchronous slave-FIFO bus that connects to a USB peripheral controller. It empties one OUT endpoint as fast as the controller supplies data. It also computes three diagnostics on the byte stream, which show whether the data path delivers what the host sent.

The control lines are fixed. The endpoint select is held at the first OUT FIFO, and the active-low read strobe and output enable stay asserted. The active-low write strobe and packet-end lines stay at their inactive high level. If those two lines were driven active during reads, the controller would corrupt the stream, so the block never drives them active.

On every rising edge of the interface clock, the block checks the empty flag. If the flag reports data present, the byte on the bus is taken. Each taken byte updates three values:
- a saturating byte counter;
- a 16-bit wrapping additive checksum;
- a saturating count of positions where a taken byte differs from the byte taken before it.

A synchronous clear zeroes all three results and the stored previous byte.

Top module: `fifo_drain_monitor`

## Requirements
- R1: From reset onward, `fifo_addr` is 2'b00, `rd_n` and `oe_n` are 0, and `wr_n` and `pktend_n` are 1, on every cycle.
- R2: A byte is taken only on a rising edge where `fifo_flag` reports not-empty. With the default `EMPTY_LVL` = 0, `fifo_flag` = 0 means empty and `fifo_flag` = 1 means data present. On edges that report empty, no result changes.
- R3: `byte_count` rises by exactly one for each taken byte, and the new value is visible after the edge that takes the byte. Two 512-byte packets sent after a clear give a count of 1024.
- R4: `checksum` is the sum of all taken bytes since the last clear or reset, modulo 2^16.
- R5: `trans_count` rises by one for each taken byte that differs from the previously taken byte. Edges that report empty do not change the stored previous byte.
- R6: After a reset or a clear, the stored previous byte is 0. A first byte of 0 therefore adds no transition, and a first nonzero byte adds one.
- R7: When `clr` is 1 at a rising edge, all three results and the previous byte become 0 after that edge. Any byte offered on that same edge is discarded.
- R8: `byte_count` and `trans_count` stop at all-ones (2^CNT_W - 1) and do not wrap.
- R9: While `rst_n` is 0 at a rising edge, all three results become 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the USB controller |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of results and previous byte |
| fifo_data | input | 8 | FIFO data bus |
| fifo_flag | input | 1 | Empty flag, polarity set by EMPTY_LVL |
| fifo_addr | output | 2 | Endpoint FIFO select, held at 0 |
| rd_n | output | 1 | Active-low read strobe, held asserted |
| oe_n | output | 1 | Active-low output enable, held asserted |
| wr_n | output | 1 | Active-low write strobe, held inactive |
| pktend_n | output | 1 | Active-low packet-end, held inactive |
| byte_count | output | CNT_W | Saturating count of taken bytes |
| checksum | output | 16 | Modulo-2^16 sum of taken bytes |
| trans_count | output | CNT_W | Saturating count of byte changes |

## Verification
A wrong stored previous byte shows up in `trans_count` one edge after the next taken byte. The count is then off by one compared with the count expected from the byte pattern. A missed or extra taken byte changes `byte_count` and `checksum` on the edge that follows.

The scoreboard compares all three results after every offered edge, so a fault is reported in the cycle it appears. Gaps where the FIFO reports empty are mixed into the stream to catch bytes taken on empty edges. A clear that coincides with a byte tests the discard rule. A narrow-counter instance reaches saturation.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
    typedef struct packed {
        logic [1:0] addr;
        logic       rd_n;
        logic       oe_n;
        logic       wr_n;
        logic       pktend_n;
    } bus_ctl_t;
endpackage

// File: rtl/fdm_ctl_drive.sv
module fdm_ctl_drive
    import fdm_pkg::*;
#(
    parameter logic [1:0] EP_SEL = 2'b00
) (
    output bus_ctl_t ctl
);
    // Read side permanently armed; write-side strobes parked high.
    always_comb begin
        ctl.addr     = EP_SEL;
        ctl.rd_n     = 1'b0;
        ctl.oe_n     = 1'b0;
        ctl.wr_n     = 1'b1;
        ctl.pktend_n = 1'b1;
    end
endmodule

// File: rtl/fdm_sat_counter.sv
module fdm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (inc && st_q.cnt != TOP)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/fdm_checksum.sv
module fdm_checksum #(
    parameter int DW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] data,
    output logic [SW-1:0] sum
);
    typedef struct packed {
        logic [SW-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.acc = '0;
        else if (en)
            st_d.acc = st_q.acc + SW'(data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.acc;
endmodule

// File: rtl/fifo_drain_monitor.sv
module fifo_drain_monitor
    import fdm_pkg::*;
#(
    parameter int         DW        = 8,
    parameter int         SW        = 16,
    parameter int         CNT_W     = 32,
    parameter bit         EMPTY_LVL = 1'b0,
    parameter logic [1:0] EP_SEL    = 2'b00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DW-1:0]    fifo_data,
    input  logic             fifo_flag,
    output logic [1:0]       fifo_addr,
    output logic             rd_n,
    output logic             oe_n,
    output logic             wr_n,
    output logic             pktend_n,
    output logic [CNT_W-1:0] byte_count,
    output logic [SW-1:0]    checksum,
    output logic [CNT_W-1:0] trans_count
);
    bus_ctl_t ctl;
    logic     has_data;
    logic     take;
    logic     differs;

    typedef struct packed {
        logic [DW-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    fdm_ctl_drive #(.EP_SEL(EP_SEL)) u_ctl (.ctl(ctl));

    assign fifo_addr = ctl.addr;
    assign rd_n      = ctl.rd_n;
    assign oe_n      = ctl.oe_n;
    assign wr_n      = ctl.wr_n;
    assign pktend_n  = ctl.pktend_n;

    generate
        if (EMPTY_LVL) begin : g_empty_hi
            assign has_data = ~fifo_flag;
        end else begin : g_empty_lo
            assign has_data = fifo_flag;
        end
    endgenerate

    // clear wins over an arriving byte
    assign take    = has_data && !clr;
    assign differs = fifo_data != st_q.prev;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.prev = '0;
        else if (has_data)
            st_d.prev = fifo_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fdm_sat_counter #(.W(CNT_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(take), .count(byte_count)
    );

    fdm_sat_counter #(.W(CNT_W)) u_trans (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(take && differs),
        .count(trans_count)
    );

    fdm_checksum #(.DW(DW), .SW(SW)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(take), .data(fifo_data),
        .sum(checksum)
    );
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
    parameter int         SW        = 16,
    parameter int         CNT_W     = 32,
    parameter bit         EMPTY_LVL = 1'b0,
    parameter logic [1:0] EP_SEL    = 2'b00
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             fifo_flag,
    input logic [1:0]       fifo_addr,
    input logic             rd_n,
    input logic             oe_n,
    input logic             wr_n,
    input logic             pktend_n,
    input logic [CNT_W-1:0] byte_count,
    input logic [SW-1:0]    checksum,
    input logic [CNT_W-1:0] trans_count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic present;
    assign present = (fifo_flag != EMPTY_LVL);

    // R1
    strobes_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_addr == EP_SEL) && !rd_n && !oe_n && wr_n && pktend_n);

    // R2
    empty_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!present && !clr) |=> ($stable(byte_count) && $stable(checksum) && $stable(trans_count)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (present && !clr && byte_count != TOP) |=> (byte_count == $past(byte_count) + 1'b1));

    // R5
    trans_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trans_count <= byte_count);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (byte_count == '0 && checksum == '0 && trans_count == '0));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count == TOP && !clr) |=> (byte_count == TOP));
endmodule

bind fifo_drain_monitor fdm_checker #(
    .SW(SW), .CNT_W(CNT_W), .EMPTY_LVL(EMPTY_LVL), .EP_SEL(EP_SEL)
) u_fdm_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fifo_flag(fifo_flag),
    .fifo_addr(fifo_addr), .rd_n(rd_n), .oe_n(oe_n), .wr_n(wr_n),
    .pktend_n(pktend_n), .byte_count(byte_count), .checksum(checksum),
    .trans_count(trans_count)
);

// File: tb/test_fifo_drain_monitor.sv
module test_fifo_drain_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  fifo_data = 8'h00;
    logic        fifo_flag = 1'b0;   // 1 = data present (default polarity)
    logic [1:0]  fifo_addr, n_addr;
    logic        rd_n, oe_n, wr_n, pktend_n;
    logic        n_rd, n_oe, n_wr, n_pe;
    logic [31:0] byte_count, trans_count;
    logic [15:0] checksum, n_sum;
    logic [3:0]  n_bytes, n_trans;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] cnt;
        logic [15:0] sum;
        logic [31:0] trn;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] m_cnt = 0, m_trn = 0;
    logic [15:0] m_sum = 0;
    logic [7:0]  m_prev = 0;

    always #2.5 clk = ~clk;

    fifo_drain_monitor i_fifo_drain_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fifo_data(fifo_data),
        .fifo_flag(fifo_flag), .fifo_addr(fifo_addr), .rd_n(rd_n),
        .oe_n(oe_n), .wr_n(wr_n), .pktend_n(pktend_n),
        .byte_count(byte_count), .checksum(checksum), .trans_count(trans_count)
    );

    fifo_drain_monitor #(.CNT_W(4)) i_fifo_drain_monitor_narrow (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fifo_data(fifo_data),
        .fifo_flag(fifo_flag), .fifo_addr(n_addr), .rd_n(n_rd),
        .oe_n(n_oe), .wr_n(n_wr), .pktend_n(n_pe),
        .byte_count(n_bytes), .checksum(n_sum), .trans_count(n_trans)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: offer one edge, update the model, push expected results
    task automatic offer(input logic v, input logic [7:0] b, input logic c, input string tag);
        @(negedge clk);
        fifo_flag = v;
        fifo_data = b;
        clr       = c;
        if (c) begin
            m_cnt = 0; m_sum = 0; m_trn = 0; m_prev = 0;
        end else if (v) begin
            if (m_cnt != 32'hFFFF_FFFF) m_cnt = m_cnt + 1;
            m_sum = m_sum + 16'(b);
            if (b != m_prev && m_trn != 32'hFFFF_FFFF) m_trn = m_trn + 1;
            m_prev = b;
        end
        @(posedge clk);
        #1;
        q.push_back('{m_cnt, m_sum, m_trn, tag});
    endtask

    // monitor: pop and compare as results appear
    initial begin
        forever begin
            exp_t e;
            wait (q.size() > 0);
            e = q.pop_front();
            chk({e.tag, " byte_count"}, byte_count, e.cnt);
            chk({e.tag, " checksum"}, 32'(checksum), 32'(e.sum));
            chk({e.tag, " trans_count"}, trans_count, e.trn);
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset values, R1 strobes during reset
        chk("R9 reset count", byte_count, 0);
        chk("R9 reset sum", 32'(checksum), 0);
        chk("R9 reset trans", trans_count, 0);
        chk("R1 ctl", {27'd0, fifo_addr, rd_n, oe_n, wr_n, pktend_n}, 32'b00_0_0_1_1);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: first byte zero after reset -> no transition
        offer(1, 8'h00, 0, "R6 zero-first");
        offer(1, 8'h00, 0, "R5 repeat");
        offer(1, 8'h5A, 0, "R5 change");
        // R2: empty edges with varying data are ignored
        for (int i = 0; i < 6; i++) offer(0, 8'(i * 37 + 1), 0, "R2 empty");
        offer(1, 8'h5A, 0, "R2 prev kept");

        // R7: clear with a byte offered the same edge
        offer(1, 8'hFF, 1, "R7 clear+byte");
        // R6: first nonzero byte after clear counts a transition
        offer(1, 8'h33, 0, "R6 nonzero-first");
        offer(1, 8'h00, 1, "R7 clear");

        // R3 R4 R5: two 512-byte packets with empty gaps
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 512; i++) begin
                if (i % 97 == 50) offer(0, 8'hEE, 0, "R2 gap");
                offer(1, (p == 0) ? 8'(i) : 8'(i / 3 + 200), 0, "R4 packet");
            end
        end
        @(negedge clk);
        chk("R3 1024 bytes", byte_count, 1024);

        // R1 after traffic
        chk("R1 ctl run", {27'd0, fifo_addr, rd_n, oe_n, wr_n, pktend_n}, 32'b00_0_0_1_1);

        // R8: narrow instance saturates at 15
        offer(1, 8'h00, 1, "R7 clear2");
        for (int i = 0; i < 20; i++) offer(1, (i % 2 == 0) ? 8'h01 : 8'h02, 0, "R8 fill");
        @(negedge clk);
        chk("R8 narrow bytes", 32'(n_bytes), 15);
        chk("R8 narrow trans", 32'(n_trans), 15);
        chk("R8 narrow sum", 32'(n_sum), 30);

        wait (q.size() == 0);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule